// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the status and protection register of a serial NOR flash slave. The register has six live bits: a busy flag, a write-enable latch, three block-protect bits and a status-write-disable bit. A command decoder upstream sends one-cycle strobes for write enable, write disable, read status, write status and program/erase start. A cycle timer returns a one-cycle done pulse when an internal operation finishes. A write-protect pin, active low, works together with the status-write-disable bit to lock the protection bits against change.

The block exposes the packed register at all times, together with a copy captured on each read-status strobe. It also exposes the block-protect field that the array logic uses to reject program and erase commands. A power-state output stays active while the chip is selected or an internal cycle is still running, so standby waits for that cycle to end. The protection bits are not truly non-volatile here. They are held in flops that reset to parameter values.

Top module: `sfl_status_ctrl`

## Requirements
- R1: After reset, busy and the write-enable latch are 0, the block-protect field equals `BP_INIT` and status-write-disable equals `SRWD_INIT`. The packed register is laid out as bit 0 busy, bit 1 write-enable latch, bits 4:2 block-protect, bit 7 status-write-disable. Bits 6:5 always read 0.
- R2: While not busy, a write-enable strobe sets the latch and a write-disable strobe clears it. Either change is visible one cycle later.
- R3: A write-status or program/erase strobe that arrives while the latch is 0 changes nothing.
- R4: An accepted write-status strobe loads status-write-disable from `wr_val_i[3]` and block-protect from `wr_val_i[2:0]`, and sets busy, all on the next cycle.
- R5: An accepted program/erase strobe sets busy and leaves the block-protect and status-write-disable bits unchanged.
- R6: A done pulse while busy clears busy and the write-enable latch on the next cycle. A done pulse while idle has no effect.
- R7: The device is hardware-protected exactly when status-write-disable is 1 and `wp_n_i` is 0. In that state a write-status strobe leaves the whole register unchanged and starts no cycle.
- R8: While busy, the write-enable, write-disable, write-status and program/erase strobes are ignored.
- R9: A read-status strobe is honoured at all times, including while busy. On the next cycle `rd_data_o` holds the register value from the strobe cycle.
- R10: `active_o` is 1 when `cs_n_i` is low or busy is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_wren_i | input | 1 | Write-enable strobe |
| cmd_wrdi_i | input | 1 | Write-disable strobe |
| cmd_rdsr_i | input | 1 | Read-status strobe |
| cmd_wrsr_i | input | 1 | Write-status strobe |
| cmd_pe_i | input | 1 | Program/erase start strobe |
| wr_val_i | input | 4 | Status write value: bit 3 disable bit, bits 2:0 block-protect |
| cyc_done_i | input | 1 | Internal cycle finished, one-cycle pulse |
| status_o | output | 8 | Live packed register |
| rd_data_o | output | 8 | Register value captured by the last read-status strobe |
| bp_o | output | 3 | Block-protect field for the array guard |
| hw_prot_o | output | 1 | Hardware-protected mode indicator |
| active_o | output | 1 | 1 in active power state, 0 in standby |

## Verification
Any wrong internal bit reaches `status_o` one cycle after the strobe that caused it, because every field is packed directly onto that port. A latch that stays set too long, or a busy flag that does not clear, therefore shows up on the next sample. An error in the protection gating is different: it shows only when a status write is attempted in that mode, as a changed field or a raised busy bit one cycle later. A stuck busy flag also holds `active_o` high after the chip select is released, which makes a missing done pulse visible at the power output.

// File: rtl/sfl_status_ctrl.sv
module sfl_status_ctrl #(
  parameter logic [2:0] BP_INIT   = 3'b000,
  parameter logic       SRWD_INIT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       cs_n_i,
  input  logic       wp_n_i,
  input  logic       cmd_wren_i,
  input  logic       cmd_wrdi_i,
  input  logic       cmd_rdsr_i,
  input  logic       cmd_wrsr_i,
  input  logic       cmd_pe_i,
  input  logic [3:0] wr_val_i,
  input  logic       cyc_done_i,
  output logic [7:0] status_o,
  output logic [7:0] rd_data_o,
  output logic [2:0] bp_o,
  output logic       hw_prot_o,
  output logic       active_o
);

  logic       busy_q, wel_q, srwd_q;
  logic [2:0] bp_q;
  logic       wrsr_ok, pe_ok;

  assign hw_prot_o = srwd_q & ~wp_n_i;
  assign wrsr_ok   = cmd_wrsr_i & wel_q & ~busy_q & ~hw_prot_o;
  assign pe_ok     = cmd_pe_i & wel_q & ~busy_q;
  assign status_o  = {srwd_q, 2'b00, bp_q, wel_q, busy_q};
  assign bp_o      = bp_q;
  assign active_o  = ~cs_n_i | busy_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
    end else if (busy_q) begin
      if (cyc_done_i) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end
    end else if (wrsr_ok || pe_ok) begin
      busy_q <= 1'b1;
    end else if (cmd_wrdi_i) begin
      wel_q <= 1'b0;
    end else if (cmd_wren_i) begin
      wel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      srwd_q <= SRWD_INIT;
      bp_q   <= BP_INIT;
    end else if (wrsr_ok) begin
      srwd_q <= wr_val_i[3];
      bp_q   <= wr_val_i[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)        rd_data_o <= 8'h00;
    else if (cmd_rdsr_i) rd_data_o <= status_o;
  end

  AST_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    status_o[6:5] == 2'b00);  // R1
  AST_NO_WEL_NO_START: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!busy_q && !wel_q) |=> !busy_q);  // R3
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && cyc_done_i) |=> (!busy_q && !wel_q));  // R6
  AST_HWPROT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hw_prot_o |=> (srwd_q == $past(srwd_q) && bp_q == $past(bp_q)));  // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && !cyc_done_i) |=> (busy_q && wel_q && $stable(bp_q) && $stable(srwd_q)));  // R8
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cmd_rdsr_i |=> rd_data_o == $past(status_o));  // R9
  AST_ACTIVE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    busy_q |-> active_o);  // R10

endmodule

// File: tb/tb_sfl_status_ctrl.sv
module tb_sfl_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wp_n = 1'b1;
  logic       wren = 1'b0, wrdi = 1'b0, rdsr = 1'b0, wrsr = 1'b0, pe = 1'b0, done = 1'b0;
  logic [3:0] wval = 4'h0;
  logic [7:0] status, rd_data;
  logic [2:0] bp;
  logic       hw_prot, active;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  sfl_status_ctrl dut (
    .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .wp_n_i(wp_n),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_rdsr_i(rdsr),
    .cmd_wrsr_i(wrsr), .cmd_pe_i(pe), .wr_val_i(wval), .cyc_done_i(done),
    .status_o(status), .rd_data_o(rd_data), .bp_o(bp),
    .hw_prot_o(hw_prot), .active_o(active)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  typedef enum {C_WREN, C_WRDI, C_RDSR, C_WRSR, C_PE, C_DONE} cmd_e;

  task automatic strobe(input cmd_e c, input logic [3:0] v = 4'h0);
    @(negedge clk);
    wval = v;
    case (c)
      C_WREN: wren = 1'b1;
      C_WRDI: wrdi = 1'b1;
      C_RDSR: rdsr = 1'b1;
      C_WRSR: wrsr = 1'b1;
      C_PE:   pe   = 1'b1;
      C_DONE: done = 1'b1;
    endcase
    @(negedge clk);
    {wren, wrdi, rdsr, wrsr, pe, done} = '0;
  endtask

  task automatic t_reset;
    check("R1 reset status", status, 8'h00);
    check("R10 standby when deselected", {7'd0, active}, 8'h00);
    cs_n = 1'b0; #1;
    check("R10 active when selected", {7'd0, active}, 8'h01);
    cs_n = 1'b1;
  endtask

  task automatic t_latch;
    strobe(C_WREN);
    check("R2 wren sets latch", status, 8'h02);
    strobe(C_WRDI);
    check("R2 wrdi clears latch", status, 8'h00);
  endtask

  task automatic t_no_latch;
    strobe(C_WRSR, 4'hF);
    check("R3 wrsr without latch", status, 8'h00);
    strobe(C_PE);
    check("R3 pe without latch", status, 8'h00);
  endtask

  task automatic t_wrsr_busy;
    strobe(C_WREN);
    strobe(C_WRSR, 4'hF);
    check("R4 wrsr loads and busy", status, 8'h9F);
    check("R4 bp output", {5'd0, bp}, 8'h07);
    check("R10 active while busy", {7'd0, active}, 8'h01);
    strobe(C_RDSR);
    check("R9 read while busy", rd_data, 8'h9F);
    strobe(C_WRDI);
    check("R8 wrdi ignored while busy", status, 8'h9F);
    strobe(C_WRSR, 4'h0);
    check("R8 wrsr ignored while busy", status, 8'h9F);
    strobe(C_DONE);
    check("R6 done clears busy and latch", status, 8'h9C);
    check("R10 standby after done", {7'd0, active}, 8'h00);
    strobe(C_DONE);
    check("R6 done while idle", status, 8'h9C);
  endtask

  task automatic t_hwprot;
    wp_n = 1'b0; #1;
    check("R7 hw protect flag", {7'd0, hw_prot}, 8'h01);
    strobe(C_WREN);
    strobe(C_WRSR, 4'h0);
    check("R7 wrsr blocked", status, 8'h9E);
    wp_n = 1'b1; #1;
    check("R7 protect off with pin high", {7'd0, hw_prot}, 8'h00);
    strobe(C_WRSR, 4'h2);
    check("R4 wrsr after unprotect", status, 8'h0B);
    strobe(C_DONE);
    check("R6 done after wrsr", status, 8'h08);
  endtask

  task automatic t_pe;
    strobe(C_WREN);
    strobe(C_PE);
    check("R5 pe sets busy, bp kept", status, 8'h0B);
    strobe(C_WREN);
    check("R8 wren ignored while busy", status, 8'h0B);
    strobe(C_PE);
    check("R8 pe ignored while busy", status, 8'h0B);
    strobe(C_DONE);
    check("R6 done after pe", status, 8'h08);
    strobe(C_RDSR);
    check("R9 read idle", rd_data, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_no_latch;
    t_wrsr_busy;
    t_hwprot;
    t_pe;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule